// File: doc/BRIEF.md
# Two-Minimum and Index Search Tree

This block serves the check-node step of a min-sum LDPC decoder. One transfer carries K = 2^M unsigned W-bit magnitudes. The block returns three results: the smallest magnitude, the second smallest magnitude, and the position of the smallest one. It does not sort the inputs.

A binary tree of compare-and-select nodes finds the first minimum. The comparison result at each tree level supplies one bit of the winner's index. Each node also hands the value that lost to the winner into a candidate list that travels up the tree with the winner. At the root the list holds the M values that lost to the overall minimum, one from each level, and a short reduction over that list gives the second minimum. No multiplexer network steered by the index is needed.

Data enters and leaves on valid/ready handshakes. A transfer happens on a clock edge where valid and ready are both high. With `REG_OUT=1` (the default) there is one output register stage. That stage takes a new input whenever it is empty or its current result is being taken in the same cycle. While the consumer holds `out_ready` low, the held result does not change. With `REG_OUT=0` the path is purely combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

Top module: `min2_search`

## Requirements
- R1: `out_min1` is the unsigned minimum of the K inputs of the accepted transfer. Input i occupies `in_data[i*W +: W]`.
- R2: `out_idx` is the position of the input that equals `out_min1`. When several inputs share the minimum, the lowest position is reported.
- R3: `out_min2` is the minimum over all inputs except position `out_idx`. It equals `out_min1` when the minimum value occurs more than once, so `out_min1 <= out_min2` always holds.
- R4: When all K inputs are equal, both minima equal that value and `out_idx` is 0.
- R5: With `REG_OUT=1`, the result of a transfer accepted at a clock edge is shown with `out_valid` high from that edge onward. Results leave in acceptance order.
- R6: With `REG_OUT=1`, `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, all three results stay unchanged.
- R7: While `rst_n` is low, `out_valid` is low. No result is presented before the first accepted transfer.
- R8: A minimum at position 0 and a minimum at position K-1 each give the correct index and the correct second minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Block can accept the input vector |
| in_data | input | K*W | K packed magnitudes, position i at bits i*W upward |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_min1 | output | W | Smallest magnitude |
| out_min2 | output | W | Second smallest magnitude |
| out_idx | output | M | Position of the smallest magnitude |

## Verification
With the register stage, a vector accepted at one edge has its three results on the outputs from that edge onward, and they stay there until an edge where `out_ready` is high. The bench drives every input just after a falling edge and checks one time unit later. At that point the outputs reflect the last rising edge, and any handshake in the coming edge is already decided. Each result is popped from a queue of expected tuples only when the bench sees a completing handshake, so a stalled result is compared again, and it must be unchanged, for as long as the stall lasts. The expected tuples come from a sort-style scan of the raw vector. Vectors are drawn from wide random values, narrow values that force ties, all-equal vectors, and vectors with the minimum pinned to the first or last position.

// File: rtl/m2s_pkg.sv
package m2s_pkg;
  // Default geometry: 6-bit magnitudes, 2^3 = 8 inputs per search.
  localparam int unsigned DEF_W = 6;
  localparam int unsigned DEF_M = 3;

  // Tie rule: the left (lower-position) operand wins unless the right one
  // is strictly smaller.
  function automatic logic right_wins(input logic [31:0] left_v, input logic [31:0] right_v);
    return right_v < left_v;
  endfunction
endpackage

// File: rtl/m2s_node.sv
module m2s_node #(
  parameter int unsigned W    = m2s_pkg::DEF_W,
  parameter int unsigned M    = m2s_pkg::DEF_M,
  parameter int unsigned SLOT = 0
) (
  input  logic [W-1:0]   a_val,
  input  logic [M-1:0]   a_idx,
  input  logic [M*W-1:0] a_cand,
  input  logic [W-1:0]   b_val,
  input  logic [M-1:0]   b_idx,
  input  logic [M*W-1:0] b_cand,
  output logic [W-1:0]   o_val,
  output logic [M-1:0]   o_idx,
  output logic [M*W-1:0] o_cand
);
  localparam logic [M*W-1:0] SLOT_MASK = {{(M*W-W){1'b0}}, {W{1'b1}}} << (SLOT*W);

  logic           pick_b;
  logic [W-1:0]   loser;
  logic [M-1:0]   win_idx;
  logic [M*W-1:0] win_cand;
  logic [M*W-1:0] loser_in_slot;

  always_comb begin
    pick_b   = m2s_pkg::right_wins(32'(a_val), 32'(b_val));
    o_val    = pick_b ? b_val  : a_val;
    loser    = pick_b ? a_val  : b_val;
    win_idx  = pick_b ? b_idx  : a_idx;
    win_cand = pick_b ? b_cand : a_cand;
    // The slot for this level is still all ones in the winner's list, so an
    // AND drops the loser in without disturbing lower-level entries.
    loser_in_slot = ((M*W)'(loser) << (SLOT*W)) | ~SLOT_MASK;
    o_cand   = win_cand & loser_in_slot;
    o_idx    = win_idx | (M'(pick_b) << SLOT);
  end

  always_comb begin
    AST_NODE_PICK: assert (o_val <= loser); // R1
  end
endmodule

// File: rtl/m2s_reduce.sv
module m2s_reduce #(
  parameter int unsigned W = m2s_pkg::DEF_W,
  parameter int unsigned M = m2s_pkg::DEF_M
) (
  input  logic [M*W-1:0] cand,
  output logic [W-1:0]   min_out
);
  logic [W-1:0] chain [M];

  assign chain[0] = cand[W-1:0];

  genvar s;
  generate
    for (s = 1; s < M; s++) begin : g_step
      assign chain[s] = (cand[s*W +: W] < chain[s-1]) ? cand[s*W +: W] : chain[s-1];
    end
  endgenerate

  assign min_out = chain[M-1];

  always_comb begin
    for (int c = 0; c < M; c++) begin
      AST_CAND_FLOOR: assert (min_out <= cand[c*W +: W]); // R3
    end
  end
endmodule

// File: rtl/min2_search.sv
module min2_search #(
  parameter int unsigned W       = m2s_pkg::DEF_W,
  parameter int unsigned M       = m2s_pkg::DEF_M,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned K      = 1 << M,
  localparam int unsigned NODES  = 2*K - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [K*W-1:0] in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_min1,
  output logic [W-1:0]   out_min2,
  output logic [M-1:0]   out_idx
);
  // Heap-ordered tree: node j has children 2j+1 (left, lower positions) and
  // 2j+2; leaves sit at K-1 .. 2K-2 in input order.
  logic [W-1:0]   t_val  [NODES];
  logic [M-1:0]   t_idx  [NODES];
  logic [M*W-1:0] t_cand [NODES];

  logic [W-1:0] c_min1;
  logic [W-1:0] c_min2;
  logic [M-1:0] c_idx;

  genvar i, d, t;
  generate
    for (i = 0; i < K; i++) begin : g_leaf
      assign t_val [K-1+i] = in_data[i*W +: W];
      assign t_idx [K-1+i] = '0;
      assign t_cand[K-1+i] = '1;
    end

    for (d = 0; d < M; d++) begin : g_depth
      for (t = 0; t < (1 << d); t++) begin : g_node
        localparam int unsigned J = (1 << d) - 1 + t;
        m2s_node #(.W(W), .M(M), .SLOT(M-1-d)) u_node (
          .a_val (t_val [2*J+1]),
          .a_idx (t_idx [2*J+1]),
          .a_cand(t_cand[2*J+1]),
          .b_val (t_val [2*J+2]),
          .b_idx (t_idx [2*J+2]),
          .b_cand(t_cand[2*J+2]),
          .o_val (t_val [J]),
          .o_idx (t_idx [J]),
          .o_cand(t_cand[J])
        );
      end
    end
  endgenerate

  m2s_reduce #(.W(W), .M(M)) u_reduce (
    .cand   (t_cand[0]),
    .min_out(c_min2)
  );

  assign c_min1 = t_val[0];
  assign c_idx  = t_idx[0];

  generate
    if (REG_OUT) begin : g_reg
      logic         v_q;
      logic [W-1:0] m1_q, m2_q;
      logic [M-1:0] ix_q;

      assign in_ready = !v_q || out_ready;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q <= 1'b0;
        end else if (in_ready) begin
          v_q <= in_valid;
        end
      end

      always_ff @(posedge clk) begin
        if (in_valid && in_ready) begin
          m1_q <= c_min1;
          m2_q <= c_min2;
          ix_q <= c_idx;
        end
      end

      assign out_valid = v_q;
      assign out_min1  = m1_q;
      assign out_min2  = m2_q;
      assign out_idx   = ix_q;

      AST_TAKE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R5
      AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_min1) && $stable(out_min2) && $stable(out_idx)); // R6
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_min1  = c_min1;
      assign out_min2  = c_min2;
      assign out_idx   = c_idx;
    end
  endgenerate

  AST_ROOT_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_data[c_idx*W +: W] == c_min1); // R2
  AST_MIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_min1 <= out_min2); // R3
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n && REG_OUT |=> !out_valid); // R7
endmodule

// File: tb/min2_search_tb.sv
module min2_search_tb;
  localparam int W = 6;
  localparam int M = 3;
  localparam int K = 1 << M;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 50000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [K*W-1:0] in_data = '0;
  logic           out_valid;
  logic           out_ready = 1'b0;
  logic [W-1:0]   out_min1, out_min2;
  logic [M-1:0]   out_idx;

  int checks = 0;
  int errors = 0;
  logic [3*16-1:0] expq [$];
  logic            prev_stall = 1'b0;
  logic [W-1:0]    prev_m1, prev_m2;
  logic [M-1:0]    prev_ix;

  always #(CLK_PERIOD/2) clk = ~clk;

  min2_search #(.W(W), .M(M), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_min1(out_min1), .out_min2(out_min2), .out_idx(out_idx)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: scan for smallest value, lowest position on ties, then
  // smallest among the remaining positions.
  function automatic logic [3*16-1:0] model(input logic [K*W-1:0] v);
    int m1 = 1 << W, ix = 0, m2 = 1 << W;
    for (int p = 0; p < K; p++)
      if (int'(v[p*W +: W]) < m1) begin m1 = int'(v[p*W +: W]); ix = p; end
    for (int p = 0; p < K; p++)
      if (p != ix && int'(v[p*W +: W]) < m2) m2 = int'(v[p*W +: W]);
    return {16'(m1), 16'(m2), 16'(ix)};
  endfunction

  function automatic logic [K*W-1:0] make_vec(input int kind);
    logic [K*W-1:0] v;
    int base = $urandom_range(1, (1 << W) - 1);
    for (int p = 0; p < K; p++) begin
      case (kind)
        0: v[p*W +: W] = W'($urandom);
        1: v[p*W +: W] = W'($urandom_range(0, 3));
        2: v[p*W +: W] = W'(base);
        3: v[p*W +: W] = (p == 0) ? W'(base - 1) : W'($urandom_range(base, (1 << W) - 1));
        default: v[p*W +: W] = (p == K-1) ? W'(base - 1) : W'($urandom_range(base, (1 << W) - 1));
      endcase
    end
    return v;
  endfunction

  task automatic cycle(input logic iv, input logic ordy, input logic [K*W-1:0] vec);
    logic [3*16-1:0] e;
    @(negedge clk);
    in_valid  = iv;
    out_ready = ordy;
    in_data   = vec;
    #1;
    check("R6 ready rule", int'(in_ready), int'(!out_valid || out_ready));
    check("R5 valid vs pending", int'(out_valid), int'(expq.size() != 0));
    if (prev_stall) begin
      check("R6 hold min1", int'(out_min1), int'(prev_m1));
      check("R6 hold min2", int'(out_min2), int'(prev_m2));
      check("R6 hold idx", int'(out_idx), int'(prev_ix));
    end
    if (out_valid && expq.size() != 0) begin
      e = expq[0];
      check("R1 min1", int'(out_min1), int'(e[47:32]));
      check("R3 min2", int'(out_min2), int'(e[31:16]));
      check("R2 idx", int'(out_idx), int'(e[15:0]));
      if (out_ready) void'(expq.pop_front());
    end
    prev_stall = out_valid && !out_ready;
    prev_m1 = out_min1; prev_m2 = out_min2; prev_ix = out_idx;
    if (in_valid && in_ready) expq.push_back(model(vec));
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [K*W-1:0] v;
    logic [3*16-1:0] e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 idle in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 idle after reset", int'(out_valid), 0);

    // R4: all-equal vector; R8: minimum at the ends.
    v = make_vec(2);
    e = model(v);
    check("R4 model idx", int'(e[15:0]), 0);
    cycle(1'b1, 1'b1, v);
    cycle(1'b1, 1'b1, make_vec(3));
    cycle(1'b1, 1'b1, make_vec(4));
    for (int n = 0; n < 3; n++) cycle(1'b1, 1'b0, make_vec(0));   // R6 stall
    cycle(1'b0, 1'b1, '0);
    cycle(1'b0, 1'b1, '0);

    for (int n = 0; n < 3000; n++)
      cycle(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0),
            make_vec($urandom_range(0, 4)));
    for (int n = 0; n < 4; n++) cycle(1'b0, 1'b1, '0);
    check("R5 queue drained", expq.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule